// File: doc/BRIEF.md
# Field memory transfer cycle sequencer

This controller drives the transfer port of a triple-port field memory used for interfield processing with flicker reduction. The memory has one write latch (port C) and two read latches (ports A and B). Port A is drained at twice the serial rate of ports B and C, so its latch must be refilled twice as often. The sequencer repeats a fixed main cycle of four transfer slots: read into latch A, read into latch B, read into latch A again, then write from latch C.

Every slot starts with an address phase. In that phase the target address is shifted out one bit per clock, with `ser_shift` marking each valid bit. The address word is the row index followed by the group index, most significant bit first. An active-low transfer strobe follows for a fixed number of clocks. Each port has its own group address counter. A counter advances by one group when a transfer for its port completes, and carries into the row index when the group index wraps. After reset the sequencer waits for `start`. Once started it runs until reset.

Top module: `field_xfer_seq`

## Requirements
- R1: After a synchronous reset and until `start` is sampled high, `ser_shift` is 0 and `xfer_n` is 1.
- R2: The first clock edge that samples `start` high in the idle state begins the address phase of a read-A slot. The first address bit is on `ser_addr` in the cycle that follows that edge.
- R3: `xfer_type` reports the current slot as read A = 0, read B = 1, write C = 2. The code 3 never appears. Slots repeat in the order 0, 1, 0, 2.
- R4: Each slot opens with exactly ROW_W+GRP_W consecutive cycles with `ser_shift` = 1. The bits carry {row, group} of the slot's port, most significant bit first. `ser_shift` is 0 outside these cycles.
- R5: `xfer_n` goes low in the cycle right after the last address bit and stays low for exactly STROBE_CYC cycles. The next slot's address phase starts in the following cycle.
- R6: Ports A, B and C each keep their own counter, starting at row 0, group 0. A counter advances by one group only after a transfer for its own port, so port A advances twice per main cycle.
- R7: A group index of 2^GRP_W-1 advances to group 0 and increments the row.
- R8: A row of ROWS-1 that receives a carry wraps to row 0.
- R9: `start` has no effect while the sequence runs: slot order, timing and addresses are unchanged.
- R10: A reset during operation returns the block to idle and clears all three counters. The next start begins again at read A with address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins the repeating sequence from idle |
| ser_addr | output | 1 | Serial address bit, most significant first |
| ser_shift | output | 1 | Marks a valid address bit on `ser_addr` |
| xfer_n | output | 1 | Active-low transfer strobe |
| xfer_type | output | 2 | Slot kind: 0 read A, 1 read B, 2 write C |

## Verification
A wrong slot counter shows up in `xfer_type` within one slot. A counter that advances on the wrong slot shows up in the serial word of the next slot for that port. Missing or extra carry logic only appears at the group and row boundaries, so the bench uses three rows and runs past a full row wrap of port A. An off-by-one in the phase counter changes the length of the shift run or the strobe run in the very first slot.

// File: rtl/fxs_pkg.sv
package fxs_pkg;

    typedef enum logic [1:0] {
        XK_RD_A = 2'd0,
        XK_RD_B = 2'd1,
        XK_WR_C = 2'd2
    } xfer_kind_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_STRB = 2'd2
    } phase_t;

    localparam int NUM_PORTS = 3;
    localparam int MAIN_SLOTS = 4;

    function automatic xfer_kind_t kind_of_slot(input logic [1:0] slot);
        case (slot)
            2'd0:    return XK_RD_A;
            2'd1:    return XK_RD_B;
            2'd2:    return XK_RD_A;
            default: return XK_WR_C;
        endcase
    endfunction

endpackage

// File: rtl/fxs_slot_ctrl.sv
module fxs_slot_ctrl
    import fxs_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int STROBE_CYC = 4,
    parameter int CNT_W      = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output phase_t           phase,
    output logic [1:0]       slot,
    output logic [CNT_W-1:0] cnt,
    output logic             step
);

    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
    localparam logic [CNT_W-1:0] STRB_LAST = CNT_W'(STROBE_CYC - 1);

    assign step = (phase == PH_STRB) && (cnt == STRB_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            slot  <= '0;
            cnt   <= '0;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_ADDR;
                        slot  <= '0;
                        cnt   <= '0;
                    end
                end
                PH_ADDR: begin
                    if (cnt == ADDR_LAST) begin
                        phase <= PH_STRB;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STRB: begin
                    if (cnt == STRB_LAST) begin
                        phase <= PH_ADDR;
                        cnt   <= '0;
                        slot  <= slot + 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fxs_group_ctr.sv
module fxs_group_ctr #(
    parameter int ROWS  = 212,
    parameter int ROW_W = 8,
    parameter int GRP_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [ROW_W-1:0] row,
    output logic [GRP_W-1:0] grp
);

    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            row <= '0;
            grp <= '0;
        end else if (adv) begin
            grp <= grp + 1'b1;
            if (&grp) begin
                row <= (row == ROW_LAST) ? '0 : row + 1'b1;
            end
        end
    end

endmodule

// File: rtl/fxs_serializer.sv
module fxs_serializer
    import fxs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int CNT_W  = 4
) (
    input  phase_t            phase,
    input  logic [CNT_W-1:0]  idx,
    input  logic [ADDR_W-1:0] word,
    output logic              bit_out,
    output logic              bit_vld
);

    logic [ADDR_W-1:0] aligned;

    always_comb begin
        aligned = word << idx;
        bit_vld = (phase == PH_ADDR);
        bit_out = bit_vld ? aligned[ADDR_W-1] : 1'b0;
    end

endmodule

// File: rtl/field_xfer_seq.sv
module field_xfer_seq
    import fxs_pkg::*;
#(
    parameter int ROWS       = 212,
    parameter int ROW_W      = 8,
    parameter int GRP_W      = 6,
    parameter int STROBE_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic       ser_addr,
    output logic       ser_shift,
    output logic       xfer_n,
    output logic [1:0] xfer_type
);

    localparam int ADDR_W = ROW_W + GRP_W;
    localparam int SPAN   = (ADDR_W > STROBE_CYC) ? ADDR_W : STROBE_CYC;
    localparam int CNT_W  = $clog2(SPAN + 1);

    phase_t            phase;
    logic [1:0]        slot;
    logic [CNT_W-1:0]  cnt;
    logic              step;
    xfer_kind_t        kind;
    logic [ADDR_W-1:0] word;
    logic [ROW_W-1:0]  rows [NUM_PORTS];
    logic [GRP_W-1:0]  grps [NUM_PORTS];

    fxs_slot_ctrl #(
        .ADDR_W    (ADDR_W),
        .STROBE_CYC(STROBE_CYC),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk  (clk),
        .rst  (rst),
        .start(start),
        .phase(phase),
        .slot (slot),
        .cnt  (cnt),
        .step (step)
    );

    assign kind = kind_of_slot(slot);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        fxs_group_ctr #(
            .ROWS (ROWS),
            .ROW_W(ROW_W),
            .GRP_W(GRP_W)
        ) u_ctr (
            .clk(clk),
            .rst(rst),
            .adv(step && (kind == xfer_kind_t'(p))),
            .row(rows[p]),
            .grp(grps[p])
        );
    end

    always_comb begin
        case (kind)
            XK_RD_A: word = {rows[0], grps[0]};
            XK_RD_B: word = {rows[1], grps[1]};
            default: word = {rows[2], grps[2]};
        endcase
    end

    fxs_serializer #(
        .ADDR_W(ADDR_W),
        .CNT_W (CNT_W)
    ) u_ser (
        .phase  (phase),
        .idx    (cnt),
        .word   (word),
        .bit_out(ser_addr),
        .bit_vld(ser_shift)
    );

    assign xfer_n    = (phase != PH_STRB);
    assign xfer_type = kind;

endmodule

// File: rtl/field_xfer_seq_chk.sv
module field_xfer_seq_chk
    import fxs_pkg::*;
#(
    parameter int ADDR_W     = 14,
    parameter int STROBE_CYC = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       ser_shift,
    input logic       xfer_n,
    input logic [1:0] xfer_type
);

    logic [31:0] shift_run;
    logic [31:0] low_run;
    logic [1:0]  seen_slot;
    logic        prev_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_run <= '0;
            low_run   <= '0;
            seen_slot <= '0;
            prev_n    <= 1'b1;
        end else begin
            shift_run <= ser_shift ? shift_run + 1 : '0;
            low_run   <= xfer_n ? '0 : low_run + 1;
            prev_n    <= xfer_n;
            if (xfer_n && !prev_n) seen_slot <= seen_slot + 1'b1;
        end
    end

    a_r4_addr_len: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_shift) && !$past(rst) |-> shift_run == ADDR_W);

    a_r4_quiet_in_strobe: assert property (@(posedge clk) disable iff (rst)
        !xfer_n |-> !ser_shift);

    a_r5_strobe_follows_addr: assert property (@(posedge clk) disable iff (rst)
        $fell(xfer_n) && !$past(rst) |-> $past(ser_shift));

    a_r5_strobe_len: assert property (@(posedge clk) disable iff (rst)
        $rose(xfer_n) && !$past(rst) |-> low_run == STROBE_CYC);

    a_r3_legal_code: assert property (@(posedge clk) disable iff (rst)
        xfer_type != 2'd3);

    a_r3_order: assert property (@(posedge clk) disable iff (rst)
        !xfer_n |-> xfer_type == 2'(kind_of_slot(seen_slot)));

endmodule

bind field_xfer_seq field_xfer_seq_chk #(
    .ADDR_W    (ADDR_W),
    .STROBE_CYC(STROBE_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ser_shift(ser_shift),
    .xfer_n   (xfer_n),
    .xfer_type(xfer_type)
);

// File: tb/field_xfer_seq_test.sv
module field_xfer_seq_test;

    localparam int ROWS       = 3;
    localparam int ROW_W      = 2;
    localparam int GRP_W      = 6;
    localparam int STROBE_CYC = 3;
    localparam int ADDR_W     = ROW_W + GRP_W;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       ser_addr, ser_shift, xfer_n;
    logic [1:0] xfer_type;

    int n_vec = 0;
    int n_bad = 0;
    int bslot = 0;
    int mrow [3];
    int mgrp [3];

    always #2 clk = ~clk;

    field_xfer_seq #(
        .ROWS(ROWS), .ROW_W(ROW_W), .GRP_W(GRP_W), .STROBE_CYC(STROBE_CYC)
    ) uut (
        .clk(clk), .rst(rst), .start(start),
        .ser_addr(ser_addr), .ser_shift(ser_shift),
        .xfer_n(xfer_n), .xfer_type(xfer_type)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int port_of(input int s);
        case (s % 4)
            0: return 0;
            1: return 1;
            2: return 0;
            default: return 2;
        endcase
    endfunction

    task automatic model_reset();
        for (int p = 0; p < 3; p++) begin
            mrow[p] = 0;
            mgrp[p] = 0;
        end
        bslot = 0;
    endtask

    task automatic check_idle(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " shift"}, ser_shift, 0);
            check({tag, " strobe"}, xfer_n, 1);
        end
    endtask

    task automatic do_slot(input string tag, input bit poke);
        int p = port_of(bslot);
        int w = 0;
        int exp_w = (mrow[p] << GRP_W) | mgrp[p];
        for (int i = 0; i < ADDR_W; i++) begin
            @(negedge clk);
            start = (poke && i == 2) ? 1'b1 : 1'b0;
            check({tag, " R4 shift"}, ser_shift, 1);
            check({tag, " R5 strobe idle in addr"}, xfer_n, 1);
            if (i == 0) check({tag, " R3 type"}, xfer_type, p);
            w = (w << 1) | int'(ser_addr);
        end
        check({tag, " R4 word"}, w, exp_w);
        for (int i = 0; i < STROBE_CYC; i++) begin
            @(negedge clk);
            start = 1'b0;
            check({tag, " R5 strobe low"}, xfer_n, 0);
            check({tag, " R4 no shift"}, ser_shift, 0);
            check({tag, " R3 type held"}, xfer_type, p);
        end
        mgrp[p]++;
        if (mgrp[p] == (1 << GRP_W)) begin
            mgrp[p] = 0;
            mrow[p] = (mrow[p] == ROWS - 1) ? 0 : mrow[p] + 1;
        end
        bslot++;
    endtask

    task automatic run_main(input int n, input string tag, input bit poke);
        for (int m = 0; m < n; m++)
            for (int s = 0; s < 4; s++) do_slot(tag, poke && s == 1);
    endtask

    task automatic t_reset_idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check_idle("R1", 6);
    endtask

    task automatic t_begin();
        model_reset();
        @(negedge clk);
        start = 1'b1;
        do_slot("R2", 1'b0);
        run_main(2, "R3 R6", 1'b0);
        do_slot("R6", 1'b0);
        do_slot("R6", 1'b0);
        do_slot("R6", 1'b0);
    endtask

    task automatic t_start_ignored();
        run_main(2, "R9", 1'b1);
    endtask

    task automatic t_wrap();
        run_main(100, "R7 R8", 1'b0);
        check("R8 port A row wrapped", int'(mrow[0] < 2), 1);
    endtask

    task automatic t_reset_mid();
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_idle("R10", 4);
        model_reset();
        @(negedge clk);
        start = 1'b1;
        run_main(1, "R10", 1'b0);
    endtask

    initial begin
        t_reset_idle();
        t_begin();
        t_start_ignored();
        t_wrap();
        t_reset_mid();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule